// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Masked Address Filter

This block is the receive half of an asynchronous serial port that carries 9-bit multiprocessor frames. Each frame has a low start bit, eight data bits sent LSB first, a ninth bit, and a stop bit. The line is sampled on a 16x oversampling enable. The start bit is confirmed at its midpoint, so short low glitches are rejected. Every later bit is then sampled once, at the middle of its 16-tick window. The block neither transmits nor generates baud rates.

When multiprocessor filtering is enabled, a frame whose ninth bit is 1 is treated as an address. It is compared against two addresses taken from a programmable own-address byte and a mask byte. The first is an individual address, in which mask bits at 0 are don't care. The second is a broadcast address, in which every position set in either the own address or the mask must be 1. A matching address selects the node, and a non-matching address deselects it. Data frames are then delivered only while the node is selected.

Frame-error detection is optional. When it is enabled, a low stop bit sets a sticky error flag that only an explicit clear removes. After a low stop bit the receiver waits for the line to return high before it looks for a new start bit.

Top module: `mpaddr_uart_rx`

## Requirements
- R1: After reset, `rx_done_o`, `fe_flag_o`, `rx_bit9_o` and `rx_data_o` are all 0.
- R2: A frame is a start bit (0), eight data bits LSB first, a ninth bit and a stop bit, each 16 `tick_i` pulses long. With filtering off, every completed frame sets `rx_done_o` and loads `rx_data_o` and `rx_bit9_o`.
- R3: A low pulse on `rx_i` that has ended before the mid-start check (8 ticks) starts no frame. It sets no flag and changes no output.
- R4: If `cfg_fe_en_i`=1 and the stop bit is sampled 0, `fe_flag_o` is set. If `cfg_fe_en_i`=0, a bad stop bit leaves `fe_flag_o` at 0.
- R5: `fe_flag_o` stays set through later frames that have valid stop bits. Only `fe_clr_i` clears it.
- R6: With `cfg_mp_en_i`=1, an address frame (ninth bit 1) is accepted if every bit position where the mask is 1 equals the own address. Acceptance sets `rx_done_o`, loads the outputs and selects the node.
- R7: With `cfg_mp_en_i`=1, an address frame is also accepted as a broadcast if it has a 1 in every position where (own address OR mask) is 1.
- R8: With `cfg_mp_en_i`=1, an address frame that matches neither address does not set `rx_done_o`, does not change `rx_data_o`, and deselects the node.
- R9: With `cfg_mp_en_i`=1, a data frame (ninth bit 0) is accepted only while the node is selected. Otherwise it is ignored and the outputs stay unchanged.
- R10: `done_clr_i` clears `rx_done_o` and `fe_clr_i` clears `fe_flag_o`. If a set and a clear of the same flag occur in the same cycle, the set wins.
- R11: After a low stop bit, the receiver ignores the line until `rx_i` is high again. A long low period therefore produces no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| cfg_own_addr_i | input | 8 | Own address byte |
| cfg_addr_mask_i | input | 8 | Address mask; 0 marks a don't-care bit in the individual match |
| cfg_mp_en_i | input | 1 | Enables multiprocessor address filtering |
| cfg_fe_en_i | input | 1 | Enables frame-error detection |
| done_clr_i | input | 1 | Clears the receive-done flag |
| fe_clr_i | input | 1 | Clears the frame-error flag |
| rx_done_o | output | 1 | Receive-done flag |
| rx_data_o | output | 8 | Data byte of the last accepted frame |
| rx_bit9_o | output | 1 | Ninth bit of the last accepted frame |
| fe_flag_o | output | 1 | Sticky frame-error flag |

## Verification
The flag updates can coincide with software clears. The end of a frame sets the error flag and the done flag in the same cycle, and a clear request may be held in that very cycle. To provoke this, the bench holds `fe_clr_i` high through a whole frame with a bad stop bit. It then releases the clear at the first sample in which `rx_done_o` is seen high. Since both flags are written by the same frame-end edge, the error flag must read 1 at that sample. Holding `done_clr_i` through a good frame must likewise still let the monitor observe a one-cycle done pulse that carries the expected byte.

// File: rtl/mpaddr_pkg.sv
package mpaddr_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_DRAIN = 2'd3
   } rx_state_e;

endpackage

// File: rtl/mpaddr_sync.sv
module mpaddr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("mpaddr_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) ff_q <= '1;
         else         ff_q <= (ff_q << 1) | STAGES'(d_i);
      end
      assign q_o = ff_q[STAGES-1];
   end

endmodule

// File: rtl/mpaddr_framer.sv
module mpaddr_framer
   import mpaddr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_i,
   input  logic              tick_i,
   output logic              frm_valid_o,
   output logic [DATA_W-1:0] frm_data_o,
   output logic              frm_ninth_o,
   output logic              frm_stop_ok_o
);

   localparam int CW       = $clog2(OVS);
   localparam int BW       = $clog2(DATA_W + 2);
   localparam int HALF     = OVS / 2;
   localparam int STOP_IDX = DATA_W + 1;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("mpaddr_framer: OVS must be even and at least 4");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("mpaddr_framer: DATA_W must be positive");
   end

   rx_state_e       state_q;
   logic [CW-1:0]   cnt_q;
   logic [BW-1:0]   idx_q;
   logic [DATA_W:0] shreg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q       <= RX_IDLE;
         cnt_q         <= '0;
         idx_q         <= '0;
         shreg_q       <= '0;
         frm_valid_o   <= 1'b0;
         frm_data_o    <= '0;
         frm_ninth_o   <= 1'b0;
         frm_stop_ok_o <= 1'b1;
      end else begin
         frm_valid_o <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               if (tick_i && !rx_i) begin
                  state_q <= RX_START;
                  cnt_q   <= '0;
               end
            end
            RX_START: begin
               if (tick_i) begin
                  if (cnt_q == CW'(HALF - 1)) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     state_q <= rx_i ? RX_IDLE : RX_BITS;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_BITS: begin
               if (tick_i) begin
                  if (cnt_q == CW'(OVS - 1)) begin
                     cnt_q <= '0;
                     if (idx_q == BW'(STOP_IDX)) begin
                        frm_valid_o   <= 1'b1;
                        frm_data_o    <= shreg_q[DATA_W-1:0];
                        frm_ninth_o   <= shreg_q[DATA_W];
                        frm_stop_ok_o <= rx_i;
                        state_q       <= rx_i ? RX_IDLE : RX_DRAIN;
                     end else begin
                        shreg_q <= {rx_i, shreg_q[DATA_W:1]};
                        idx_q   <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_DRAIN: begin
               if (rx_i) state_q <= RX_IDLE;
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   // A completed frame is reported for exactly one cycle
   assert_valid_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frm_valid_o |=> !frm_valid_o);

   // Bit reception only begins when the line was still low at mid-start
   assert_start_confirmed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == RX_BITS && $past(state_q) == RX_START) |-> !$past(rx_i));

   // After a bad stop bit, a low line never leads back to start detection
   assert_drain_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == RX_DRAIN && !rx_i) |=> state_q == RX_DRAIN);

endmodule

// File: rtl/mpaddr_addr_match.sv
module mpaddr_addr_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic [DATA_W-1:0] own_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              hit_given_o,
   output logic              hit_bcast_o
);

   logic [DATA_W-1:0] given_addr;
   logic [DATA_W-1:0] bcast_addr;
   logic [DATA_W-1:0] given_ok;
   logic [DATA_W-1:0] bcast_ok;

   assign given_addr = own_i & mask_i;
   assign bcast_addr = own_i | mask_i;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign given_ok[i] = !mask_i[i] || (byte_i[i] == given_addr[i]);
      assign bcast_ok[i] = !bcast_addr[i] || byte_i[i];
   end

   assign hit_given_o = &given_ok;
   assign hit_bcast_o = &bcast_ok;

endmodule

// File: rtl/mpaddr_uart_rx.sv
module mpaddr_uart_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic [DATA_W-1:0] cfg_own_addr_i,
   input  logic [DATA_W-1:0] cfg_addr_mask_i,
   input  logic              cfg_mp_en_i,
   input  logic              cfg_fe_en_i,
   input  logic              done_clr_i,
   input  logic              fe_clr_i,
   output logic              rx_done_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_bit9_o,
   output logic              fe_flag_o
);

   logic              rx_sync;
   logic              frm_valid;
   logic [DATA_W-1:0] frm_data;
   logic              frm_ninth;
   logic              frm_stop_ok;
   logic              hit_given;
   logic              hit_bcast;
   logic              selected_q;
   logic              addr_hit;
   logic              accept;
   logic              fe_set;

   mpaddr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (rx_i),
      .q_o    (rx_sync)
   );

   mpaddr_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .rx_i          (rx_sync),
      .tick_i        (tick_i),
      .frm_valid_o   (frm_valid),
      .frm_data_o    (frm_data),
      .frm_ninth_o   (frm_ninth),
      .frm_stop_ok_o (frm_stop_ok)
   );

   mpaddr_addr_match #(.DATA_W(DATA_W)) u_match (
      .byte_i      (frm_data),
      .own_i       (cfg_own_addr_i),
      .mask_i      (cfg_addr_mask_i),
      .hit_given_o (hit_given),
      .hit_bcast_o (hit_bcast)
   );

   assign addr_hit = hit_given || hit_bcast;
   assign accept   = frm_valid &&
                     (!cfg_mp_en_i || (frm_ninth ? addr_hit : selected_q));
   assign fe_set   = frm_valid && !frm_stop_ok && cfg_fe_en_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         selected_q <= 1'b0;
         rx_done_o  <= 1'b0;
         fe_flag_o  <= 1'b0;
         rx_data_o  <= '0;
         rx_bit9_o  <= 1'b0;
      end else begin
         if (frm_valid && cfg_mp_en_i && frm_ninth) selected_q <= addr_hit;
         if (accept)          rx_done_o <= 1'b1;
         else if (done_clr_i) rx_done_o <= 1'b0;
         if (fe_set)          fe_flag_o <= 1'b1;
         else if (fe_clr_i)   fe_flag_o <= 1'b0;
         if (accept) begin
            rx_data_o <= frm_data;
            rx_bit9_o <= frm_ninth;
         end
      end
   end

   // The error flag only rises on an enabled bad-stop frame
   assert_fe_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fe_flag_o) |-> $past(frm_valid && !frm_stop_ok && cfg_fe_en_i));

   // The error flag holds until software clears it
   assert_fe_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fe_flag_o && !fe_clr_i) |=> fe_flag_o);

   // Address frames raise done only on an individual or broadcast hit
   assert_addr_filter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(rx_done_o) && $past(cfg_mp_en_i && frm_ninth)) |-> $past(addr_hit));

   // Data frames in filter mode raise done only for a selected node
   assert_data_selected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(rx_done_o) && $past(cfg_mp_en_i && !frm_ninth)) |-> $past(selected_q));

   // Done never rises without a completed frame
   assert_done_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rx_done_o) |-> $past(frm_valid));

endmodule

// File: tb/tb_mpaddr_uart_rx.sv
module tb_mpaddr_uart_rx;

   localparam int DW      = 8;
   localparam int BIT_CLK = 32;   // 16 ticks, one tick every 2 clocks

   typedef struct packed { logic [DW-1:0] d; logic b9; } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_i = 1'b1;
   logic          tick_i = 1'b0;
   logic [DW-1:0] own = 8'h35;
   logic [DW-1:0] mask = 8'hF0;
   logic          mp_en = 1'b0;
   logic          fe_en = 1'b0;
   logic          done_clr = 1'b0;
   logic          fe_clr = 1'b0;
   logic          rx_done;
   logic [DW-1:0] rx_data;
   logic          rx_bit9;
   logic          fe_flag;

   int   n_tests = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   exp_t sb_q[$];
   logic [DW-1:0] exp_data = '0;
   string unexp_tag = "R8";

   mpaddr_uart_rx dut (
      .clk_i (clk), .rst_ni (rst_n), .rx_i (rx_i), .tick_i (tick_i),
      .cfg_own_addr_i (own), .cfg_addr_mask_i (mask),
      .cfg_mp_en_i (mp_en), .cfg_fe_en_i (fe_en),
      .done_clr_i (done_clr), .fe_clr_i (fe_clr),
      .rx_done_o (rx_done), .rx_data_o (rx_data),
      .rx_bit9_o (rx_bit9), .fe_flag_o (fe_flag)
   );

   always #2.5 clk = ~clk;
   always @(negedge clk) tick_i <= ~tick_i;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // monitor: pops one expected item per rising done
   initial begin
      logic prev;
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (rx_done && !prev) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, unexp_tag, 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(rx_data == e.d, "R2 data", rx_data, e.d);
               chk(rx_bit9 == e.b9, "R2 ninth", rx_bit9, e.b9);
            end
         end
         prev = rx_done;
      end
   end

   task automatic put_bit(input logic v);
      rx_i = v;
      repeat (BIT_CLK) @(negedge clk);
   endtask

   task automatic drive_frame(input logic [DW-1:0] d, input logic b9, input logic stp);
      put_bit(1'b0);
      for (int i = 0; i < DW; i++) put_bit(d[i]);
      put_bit(b9);
      put_bit(stp);
      put_bit(1'b1);
   endtask

   task automatic clear_done();
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [DW-1:0] d, input logic b9, input logic stp,
                             input bit acc, input string req);
      if (acc) sb_q.push_back('{d: d, b9: b9});
      unexp_tag = req;
      drive_frame(d, b9, stp);
      chk(rx_done == acc, req, rx_done, acc);
      if (acc) exp_data = d;
      chk(rx_data == exp_data, req, rx_data, exp_data);
      clear_done();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(rx_done == 1'b0, "R1 done", rx_done, 0);
      chk(fe_flag == 1'b0, "R1 fe", fe_flag, 0);
      chk(rx_data == '0, "R1 data", rx_data, 0);
      chk(rx_bit9 == 1'b0, "R1 ninth", rx_bit9, 0);
      rst_n = 1'b1;
      repeat (BIT_CLK) @(negedge clk);

      // R2 plain reception, filtering off
      send_frame(8'hA5, 1'b0, 1'b1, 1, "R2");
      send_frame(8'h3C, 1'b1, 1'b1, 1, "R2");
      chk(rx_bit9 == 1'b1, "R2 ninth kept", rx_bit9, 1);

      // R3 glitch shorter than half a bit
      unexp_tag = "R3";
      rx_i = 1'b0;
      repeat (8) @(negedge clk);
      rx_i = 1'b1;
      repeat (3 * BIT_CLK) @(negedge clk);
      chk(rx_done == 1'b0, "R3 done", rx_done, 0);
      chk(rx_data == 8'h3C, "R3 data", rx_data, 8'h3C);
      send_frame(8'h5A, 1'b0, 1'b1, 1, "R3");

      // R4 + R11 bad stop with long low tail
      fe_en = 1'b1;
      sb_q.push_back('{d: 8'h55, b9: 1'b0});
      put_bit(1'b0);
      for (int i = 0; i < DW; i++) put_bit(i % 2 == 0);
      put_bit(1'b0);
      put_bit(1'b0);
      chk(rx_done == 1'b1, "R4 done", rx_done, 1);
      chk(fe_flag == 1'b1, "R4 fe set", fe_flag, 1);
      exp_data = 8'h55;
      clear_done();
      unexp_tag = "R11";
      repeat (14) put_bit(1'b0);
      chk(rx_done == 1'b0, "R11 no frame", rx_done, 0);
      put_bit(1'b1);
      put_bit(1'b1);
      // R5 sticky through a valid frame
      send_frame(8'h81, 1'b0, 1'b1, 1, "R11");
      chk(fe_flag == 1'b1, "R5 sticky", fe_flag, 1);
      fe_clr = 1'b1;
      @(negedge clk);
      fe_clr = 1'b0;
      @(negedge clk);
      chk(fe_flag == 1'b0, "R5 cleared", fe_flag, 0);

      // R4 detection disabled
      fe_en = 1'b0;
      send_frame(8'h0F, 1'b0, 1'b0, 1, "R4");
      chk(fe_flag == 1'b0, "R4 disabled", fe_flag, 0);

      // R10 set wins over held fe clear
      fe_en = 1'b1;
      fe_clr = 1'b1;
      sb_q.push_back('{d: 8'hC3, b9: 1'b0});
      fork
         drive_frame(8'hC3, 1'b0, 1'b0);
         begin
            do @(negedge clk); while (!rx_done);
            chk(fe_flag == 1'b1, "R10 fe set wins", fe_flag, 1);
            fe_clr = 1'b0;
         end
      join
      exp_data = 8'hC3;
      chk(fe_flag == 1'b1, "R10 fe held", fe_flag, 1);
      clear_done();
      fe_clr = 1'b1;
      @(negedge clk);
      fe_clr = 1'b0;
      fe_en = 1'b0;

      // R10 set wins over held done clear
      done_clr = 1'b1;
      sb_q.push_back('{d: 8'h96, b9: 1'b0});
      drive_frame(8'h96, 1'b0, 1'b1);
      exp_data = 8'h96;
      chk(sb_q.size() == 0, "R10 done pulse seen", sb_q.size(), 0);
      chk(rx_done == 1'b0, "R10 done cleared", rx_done, 0);
      done_clr = 1'b0;
      @(negedge clk);

      // Multiprocessor filtering: own 0x35, mask 0xF0
      mp_en = 1'b1;
      send_frame(8'h11, 1'b0, 1'b1, 0, "R9");
      send_frame(8'h3A, 1'b1, 1'b1, 1, "R6");
      send_frame(8'h22, 1'b0, 1'b1, 1, "R9");
      send_frame(8'h3F, 1'b1, 1'b1, 1, "R6");
      send_frame(8'h4A, 1'b1, 1'b1, 0, "R8");
      send_frame(8'h33, 1'b0, 1'b1, 0, "R8");
      send_frame(8'hF7, 1'b1, 1'b1, 1, "R7");
      send_frame(8'h44, 1'b0, 1'b1, 1, "R7");
      send_frame(8'hF4, 1'b1, 1'b1, 0, "R7");
      send_frame(8'hE5, 1'b1, 1'b1, 0, "R7");
      send_frame(8'h66, 1'b0, 1'b1, 0, "R9");
      send_frame(8'hFD, 1'b1, 1'b1, 1, "R7");

      chk(sb_q.size() == 0, "R2 scoreboard empty", sb_q.size(), 0);
      summary();
   end

endmodule